// File: doc/BRIEF.md
# Serial Control Word Receiver

This block is a write-only, three-wire serial slave that loads a 16-bit control word into a parallel register. The three pins are a serial clock, a serial data line and an active-high enable. All three are resynchronised into a faster system clock. Data bits are taken on rising edges of the serial clock, least significant bit first. The register is written only when a complete word has arrived inside one enable window. A partial word is thrown away.

The committed word is split into named control fields for the rest of the chip:
- an active-low reset request
- a two-bit output mode
- master or slave select
- word resolution
- zero-cross disable
- a five-bit volume code
- a bypass charge-rate doubler

Each commit raises a single-cycle update strobe, so consumers can tell that a new word has landed.

Top module: `serial_ctl_reg`

## Requirements
- R1: After reset, `ctlWord`, every decoded field and `updStrobe` are all 0.
- R2: A word is 16 bits sent least significant bit first: the first bit sampled lands in `ctlWord[0]` and the sixteenth in `ctlWord[15]`.
- R3: A data bit is taken from `sdata` at each rising edge of `sclk` while `sen` is high.
- R4: The word is committed at the sixteenth rising edge of `sclk` within the enable window, while `sen` is still high. `updStrobe` is high for exactly one system clock cycle per commit, in the cycle in which `ctlWord` takes its new value.
- R5: If `sen` falls before the sixteenth rising edge, the transfer is aborted. `ctlWord` keeps its old value and `updStrobe` stays low.
- R6: Rising edges of `sclk` after the sixteenth in the same enable window are ignored. Only the first 16 bits are kept, and there is only one strobe.
- R7: Each rising edge of `sen` starts a new frame at bit 0, even after an aborted partial frame.
- R8: The decoded fields are:
  - `resetN` = bit 0
  - `outMode` = bits 2:1, where 00 is off, 01 is standby, 10 is mute and 11 is active
  - `isMaster` = bit 3, where 1 means master
  - `wide32` = bit 4, where 1 means 32-bit resolution
  - `zcDisable` = bit 6
  - `volume` = bits 11:7
  - `bypFast` = bit 12

  Reserved bits 5 and 13 to 15 are stored in `ctlWord` but drive no field.
- R9: `sclk` edges while `sen` is low do not change `ctlWord` and do not raise `updStrobe`.
- R10: Every completed frame produces a strobe, even when it carries the same value as the register already holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock pin |
| sdata | input | 1 | Serial data pin |
| sen | input | 1 | Active-high frame enable pin |
| ctlWord | output | 16 | Committed control word |
| resetN | output | 1 | Active-low reset field (bit 0) |
| outMode | output | 2 | Output mode field (bits 2:1) |
| isMaster | output | 1 | Master select field (bit 3) |
| wide32 | output | 1 | 32-bit resolution field (bit 4) |
| zcDisable | output | 1 | Zero-cross disable field (bit 6) |
| volume | output | 5 | Volume code field (bits 11:7) |
| bypFast | output | 1 | Bypass charge-rate doubler field (bit 12) |
| updStrobe | output | 1 | One-cycle pulse on each commit |

## Verification
The main function is driven with a handful of complete frames: all ones, all zeros, alternating bits and asymmetric words. Asymmetric words separate LSB-first ordering from MSB-first, and they catch any field taken from the wrong bit. Frame-length patterns tell the framing rules apart:
- A short frame must leave the register untouched.
- An over-long frame must keep only its first sixteen bits.
- A full frame right after an aborted one shows whether the bit counter restarts.

Clocks sent with enable low, a repeated identical word, and a check taken while enable is still high separate stray commits, missing strobes and commits deferred to the enable fall.

// File: rtl/ctlreg_pkg.sv
package ctlreg_pkg;
  localparam int WORD_W      = 16;
  localparam int POS_RESET   = 0;
  localparam int POS_MODE_LO = 1;
  localparam int MODE_W      = 2;
  localparam int POS_MASTER  = 3;
  localparam int POS_WIDE    = 4;
  localparam int POS_ZCDIS   = 6;
  localparam int POS_VOL_LO  = 7;
  localparam int VOL_W       = 5;
  localparam int POS_BYP     = 12;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'b00,
    MODE_STBY = 2'b01,
    MODE_MUTE = 2'b10,
    MODE_RUN  = 2'b11
  } outMode_t;

  typedef struct packed {
    logic frameStart;
    logic shiftEn;
    logic commit;
  } ctlStrobe_t;
endpackage

// File: rtl/ctlreg_sync.sv
module ctlreg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclkIn,
  input  logic sdataIn,
  input  logic senIn,
  output logic sclkRise,
  output logic dataBit,
  output logic enLvl,
  output logic enRise
);
  localparam int PIN_N = 3;

  logic [PIN_N-1:0] stage [STAGES];
  logic [PIN_N-1:0] lastLvl;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage[g] <= '0;
          else        stage[g] <= {senIn, sdataIn, sclkIn};
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage[g] <= '0;
          else        stage[g] <= stage[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lastLvl <= '0;
    else        lastLvl <= stage[STAGES-1];
  end

  always_comb begin
    sclkRise = stage[STAGES-1][0] & ~lastLvl[0];
    dataBit  = stage[STAGES-1][1];
    enLvl    = stage[STAGES-1][2];
    enRise   = stage[STAGES-1][2] & ~lastLvl[2];
  end

  // R3: a rising edge is never reported in two consecutive cycles
  a_r3_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
    sclkRise |=> !sclkRise);
endmodule

// File: rtl/ctlreg_ctrl.sv
module ctlreg_ctrl
  import ctlreg_pkg::*;
#(
  parameter int WIDTH = WORD_W
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sclkRise,
  input  logic       enLvl,
  input  logic       enRise,
  output ctlStrobe_t stb
);
  localparam int CNT_W = $clog2(WIDTH + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WIDTH);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WIDTH - 1);

  logic [CNT_W-1:0] bitCnt;

  always_comb begin
    stb.frameStart = enRise;
    stb.shiftEn    = enLvl & sclkRise & (enRise | (bitCnt < CNT_FULL));
    stb.commit     = stb.shiftEn & !enRise & (bitCnt == CNT_LAST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           bitCnt <= '0;
    else if (!enLvl)      bitCnt <= '0;
    else if (enRise)      bitCnt <= stb.shiftEn ? CNT_W'(1) : '0;
    else if (stb.shiftEn) bitCnt <= bitCnt + 1'b1;
  end

  // R6: the counter saturates at one full word
  a_r6_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    bitCnt <= CNT_FULL);
  // R5: dropping enable discards progress
  a_r5_abort_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !enLvl |=> (bitCnt == '0));
  // R4: a commit only happens inside an enable window
  a_r4_commit_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    stb.commit |-> enLvl);
  // R6: after a commit, further edges in the window cannot commit again
  a_r6_no_recommit: assert property (@(posedge clk) disable iff (!rst_n)
    stb.commit |=> !stb.commit);
endmodule

// File: rtl/ctlreg_dp.sv
module ctlreg_dp
  import ctlreg_pkg::*;
#(
  parameter int WIDTH = WORD_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctlStrobe_t       stb,
  input  logic             dataBit,
  output logic [WIDTH-1:0] ctlWord,
  output logic             updStrobe
);
  logic [WIDTH-1:0] shReg;
  logic [WIDTH-1:0] shNext;

  always_comb shNext = {dataBit, shReg[WIDTH-1:1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          shReg <= '0;
    else if (stb.shiftEn) shReg <= stb.frameStart ? {dataBit, {(WIDTH-1){1'b0}}} : shNext;
    else if (stb.frameStart) shReg <= '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctlWord   <= '0;
      updStrobe <= 1'b0;
    end else begin
      updStrobe <= stb.commit;
      if (stb.commit) ctlWord <= shNext;
    end
  end

  // R4: the strobe is a single-cycle pulse
  a_r4_strobe_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    updStrobe |=> !updStrobe);
  // R5: the register only moves together with the strobe
  a_r5_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !updStrobe |-> $stable(ctlWord));
endmodule

// File: rtl/serial_ctl_reg.sv
module serial_ctl_reg
  import ctlreg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              sdata,
  input  logic              sen,
  output logic [WORD_W-1:0] ctlWord,
  output logic              resetN,
  output logic [MODE_W-1:0] outMode,
  output logic              isMaster,
  output logic              wide32,
  output logic              zcDisable,
  output logic [VOL_W-1:0]  volume,
  output logic              bypFast,
  output logic              updStrobe
);
  logic       sclkRise, dataBit, enLvl, enRise;
  ctlStrobe_t stb;

  ctlreg_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sclkIn(sclk), .sdataIn(sdata), .senIn(sen),
    .sclkRise(sclkRise), .dataBit(dataBit), .enLvl(enLvl), .enRise(enRise));

  ctlreg_ctrl #(.WIDTH(WORD_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .sclkRise(sclkRise), .enLvl(enLvl),
    .enRise(enRise), .stb(stb));

  ctlreg_dp #(.WIDTH(WORD_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .dataBit(dataBit),
    .ctlWord(ctlWord), .updStrobe(updStrobe));

  always_comb begin
    resetN    = ctlWord[POS_RESET];
    outMode   = ctlWord[POS_MODE_LO +: MODE_W];
    isMaster  = ctlWord[POS_MASTER];
    wide32    = ctlWord[POS_WIDE];
    zcDisable = ctlWord[POS_ZCDIS];
    volume    = ctlWord[POS_VOL_LO +: VOL_W];
    bypFast   = ctlWord[POS_BYP];
  end

  // R9: no strobe without an active enable shortly before
  a_r9_strobe_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(updStrobe) |-> $past(enLvl));
endmodule

// File: tb/serial_ctl_reg_bench.sv
module serial_ctl_reg_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, sdata = 1'b0, sen = 1'b0;
  logic [15:0] ctlWord;
  logic resetN, isMaster, wide32, zcDisable, bypFast, updStrobe;
  logic [1:0] outMode;
  logic [4:0] volume;

  int checks = 0;
  int fails  = 0;
  int strobes = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  serial_ctl_reg u_serial_ctl_reg (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdata(sdata), .sen(sen),
    .ctlWord(ctlWord), .resetN(resetN), .outMode(outMode), .isMaster(isMaster),
    .wide32(wide32), .zcDisable(zcDisable), .volume(volume), .bypFast(bypFast),
    .updStrobe(updStrobe));

  always @(negedge clk) if (rst_n && updStrobe) strobes++;

  localparam int NVEC = 6;
  localparam logic [15:0] STIM [NVEC] = '{16'hFFFF, 16'h0000, 16'h1234,
                                          16'hAAAA, 16'h5555, 16'h0F81};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // bits sent LSB first; n clocks; leaves enable high if keepEn
  task automatic sendFrame(input logic [31:0] bits, input int n, input bit keepEn);
    sen = 1'b1;
    waitClk(6);
    for (int i = 0; i < n; i++) begin
      sdata = bits[i];
      sclk = 1'b0;
      waitClk(4);
      sclk = 1'b1;
      waitClk(4);
    end
    sclk = 1'b0;
    waitClk(6);
    if (!keepEn) begin
      sen = 1'b0;
      waitClk(8);
    end
  endtask

  task automatic checkFields(input string req, input logic [15:0] w);
    check(req, ctlWord, w);
    check({req, " R8 resetN"}, resetN, w[0]);
    check({req, " R8 outMode"}, outMode, w[2:1]);
    check({req, " R8 isMaster"}, isMaster, w[3]);
    check({req, " R8 wide32"}, wide32, w[4]);
    check({req, " R8 zcDisable"}, zcDisable, w[6]);
    check({req, " R8 volume"}, volume, w[11:7]);
    check({req, " R8 bypFast"}, bypFast, w[12]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    int s0;
    waitClk(4);
    // R1: reset state
    checkFields("R1 reset", 16'h0000);
    check("R1 strobe", updStrobe, 1'b0);
    rst_n = 1'b1;
    waitClk(4);
    check("R1 after release", ctlWord, 16'h0000);

    // R2/R3/R8/R10: table of full frames
    for (int v = 0; v < NVEC; v++) begin
      s0 = strobes;
      sendFrame({16'h0, STIM[v]}, 16, 1'b0);
      checkFields("R2 R3 table", STIM[v]);
      check("R10 table strobe", strobes - s0, 1);
    end

    // R4: commit at sixteenth edge, while enable still high
    s0 = strobes;
    sendFrame({16'h0, 16'h3C5A}, 16, 1'b1);
    check("R4 before enable fall", ctlWord, 16'h3C5A);
    check("R4 strobe before enable fall", strobes - s0, 1);
    sen = 1'b0; waitClk(8);

    // R5: aborted short frame
    s0 = strobes;
    sendFrame({16'h0, 16'hFFFF}, 9, 1'b0);
    check("R5 abort keeps word", ctlWord, 16'h3C5A);
    check("R5 abort no strobe", strobes - s0, 0);

    // R7: next frame starts at bit 0
    s0 = strobes;
    sendFrame({16'h0, 16'hA5C3}, 16, 1'b0);
    checkFields("R7 restart", 16'hA5C3);
    check("R7 strobe", strobes - s0, 1);

    // R6: extra clocks ignored
    s0 = strobes;
    sendFrame({16'hFFFF, 16'h0246}, 22, 1'b0);
    check("R6 first 16 kept", ctlWord, 16'h0246);
    check("R6 one strobe", strobes - s0, 1);

    // R9: clocks with enable low
    s0 = strobes;
    for (int i = 0; i < 20; i++) begin
      sdata = i[0]; sclk = 1'b1; waitClk(4); sclk = 1'b0; waitClk(4);
    end
    waitClk(8);
    check("R9 idle clocks word", ctlWord, 16'h0246);
    check("R9 idle clocks strobe", strobes - s0, 0);

    // R10: same value twice gives two strobes
    s0 = strobes;
    sendFrame({16'h0, 16'h0246}, 16, 1'b0);
    sendFrame({16'h0, 16'h0246}, 16, 1'b0);
    check("R10 repeat strobes", strobes - s0, 2);
    check("R10 repeat word", ctlWord, 16'h0246);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule